// File: doc/BRIEF.md
# Parity-Checked Write-Through Data Cache

A direct-mapped data cache holding one data word per line, with a valid flag and an address tag per line. Every word in the data array carries one even-parity bit, equal to the XOR of its data bits. The bit is recomputed whenever the word is written, either by a fill from the next level or by a store. Stores always go straight through to the next level, so no line is ever dirty and the level below always holds a correct copy of every word the cache holds.

When a load hits a line, the data bits are checked against the stored parity bit. A mismatch does not raise an error. The line is invalidated, the word is read again from the next level, and the load returns that clean word. To the core this looks like a slower miss. A saturating counter records how many refetches parity mismatches have caused. A test port can flip any one bit of any line, including the parity bit, so the recovery path can be exercised.

The core side uses a valid/ready request channel and a one-cycle response pulse. The next-level side uses a valid/ready request channel and a response-valid pulse. Only one request is outstanding at a time.

Top module: `parity_wt_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, `refetch_count` is 0, and every line is invalid, so the first load to any address goes to the next level.
- R2: A load whose index holds a valid line with a matching tag and correct parity is answered with `rsp_valid` in the cycle right after acceptance, returns the stored word, and issues no next-level request.
- R3: A load that misses issues exactly one next-level read at the load address. It fills the line from the response and returns the response word. A later load to the same address then hits.
- R4: The parity bit written with a word, on a fill or on a store, is the XOR of all data bits of that word (even parity over data plus parity).
- R5: A load that hits a line whose data has one flipped bit raises no error. The line is invalidated, one next-level read is issued, and the load returns the correct word from the next level.
- R6: A flip of the parity bit alone (injection bit index equal to the word width) is detected and handled exactly as in R5, even though the data bits are intact.
- R7: Every store writes its address and data to the next level. A store whose address is cached also updates the cached word. A store that misses leaves the line at that index unchanged and allocates nothing.
- R8: `refetch_count` rises by one for each parity-triggered refetch and never for an ordinary miss. It holds at 2^CNT_W-1 once it gets there.
- R9: `req_ready` is low from the cycle after acceptance until the response cycle. Each request, load or store, produces exactly one one-cycle `rsp_valid` pulse. `req_ready` returns high in the cycle after the pulse.
- R10: Parity misses an even number of bit flips. Two flips of different bits in one cached word give a clean hit that returns the corrupted word. Flipping the same bit twice gives a clean hit that returns the original word.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | W | Load data (unspecified for stores) |
| mem_req_valid | output | 1 | Next-level request valid |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_we | output | 1 | Next-level request is a write |
| mem_req_addr | output | AW | Next-level word address |
| mem_req_wdata | output | W | Next-level write data |
| mem_rsp_valid | input | 1 | Next-level read data valid |
| mem_rsp_rdata | input | W | Next-level read data |
| inj_en | input | 1 | Flip one stored bit this cycle |
| inj_line | input | log2(LINES) | Line to corrupt |
| inj_bit | input | log2(W+1) | Bit to flip; value W selects the parity bit |
| refetch_count | output | CNT_W | Saturating count of parity-triggered refetches |

## Verification
The bench corrupts cached words with single data-bit flips and parity-bit flips, then loads them. A design that skipped the check would return the corrupted word, and one that ignored the parity bit would miss the R6 case. It keeps a shadow of valid lines and tags, so it knows when a load should be a clean one-cycle hit, an ordinary miss or a refetch. That lets it catch a counter that also counts plain misses, or a hit path that still touches the next level. Stores to a cached address and to a conflicting uncached address check both the write-through and the no-allocate rule. Two-flip patterns confirm that an even number of flips slips past the check, which exposes parity computed over the wrong bits. The counter is driven to saturation and one step past it, to catch wrap-around.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // accepting a core request
        ST_MREQ  = 2'd1,   // next-level request outstanding
        ST_MWAIT = 2'd2,   // waiting for next-level read data
        ST_RESP  = 2'd3    // one-cycle response to the core
    } pwc_state_e;

endpackage

// File: rtl/pwc_parity.sv
module pwc_parity #(
    parameter int W = 32
) (
    input  logic [W-1:0] data,
    output logic         par
);
    // Even parity: stored bit makes the total count of ones even
    assign par = ^data;
endmodule

// File: rtl/pwc_sat_cnt.sv
module pwc_sat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        (inc && count != CNT_MAX) |=> count == $past(count) + 1'b1);
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
        count == CNT_MAX |=> count == CNT_MAX);
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int W     = 32,
    parameter int LINES = 16,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int BIT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    // lookup port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [W-1:0]     rd_data,
    output logic             rd_par,
    // write port (fill or store)
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [W-1:0]     wr_data,
    // invalidate port
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    // fault injection
    input  logic             inj_en,
    input  logic [IDX_W-1:0] inj_idx,
    input  logic [BIT_W-1:0] inj_bit
);
    logic [W-1:0]     data_q [LINES];
    logic             par_q  [LINES];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [LINES-1:0] valid_q;

    logic       wr_par;
    logic [W:0] inj_mask;

    pwc_parity #(.W(W)) u_gen (.data(wr_data), .par(wr_par));

    assign inj_mask = {{W{1'b0}}, 1'b1} << inj_bit;

    always_ff @(posedge clk) begin
        for (int l = 0; l < LINES; l++) begin
            if (wr_en && wr_idx == IDX_W'(l)) begin
                data_q[l] <= wr_data;
                par_q[l]  <= wr_par;
                tag_q[l]  <= wr_tag;
            end else if (inj_en && inj_idx == IDX_W'(l)) begin
                {par_q[l], data_q[l]} <= {par_q[l], data_q[l]} ^ inj_mask;
            end
            if (rst)
                valid_q[l] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(l))
                valid_q[l] <= 1'b1;
            else if (inv_en && inv_idx == IDX_W'(l))
                valid_q[l] <= 1'b0;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_par   = par_q[rd_idx];

    // Checker state: which line was written / invalidated last cycle
    logic             wchk_q, ichk_q;
    logic [IDX_W-1:0] wchk_idx_q, ichk_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wchk_q <= 1'b0;
            ichk_q <= 1'b0;
        end else begin
            wchk_q <= wr_en;
            ichk_q <= inv_en && !(wr_en && wr_idx == inv_idx);
        end
        wchk_idx_q <= wr_idx;
        ichk_idx_q <= inv_idx;
    end

    p_write_even_r4: assert property (@(posedge clk) disable iff (rst)
        wchk_q |-> ((^data_q[wchk_idx_q]) == par_q[wchk_idx_q] && valid_q[wchk_idx_q]));
    p_inval_r5: assert property (@(posedge clk) disable iff (rst)
        ichk_q |-> !valid_q[ichk_idx_q]);
endmodule

// File: rtl/parity_wt_cache.sv
module parity_wt_cache
    import pwc_pkg::*;
#(
    parameter int W     = 32,
    parameter int AW    = 12,
    parameter int LINES = 16,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int BIT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [W-1:0]     req_wdata,
    output logic             rsp_valid,
    output logic [W-1:0]     rsp_rdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [AW-1:0]    mem_req_addr,
    output logic [W-1:0]     mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [W-1:0]     mem_rsp_rdata,
    input  logic             inj_en,
    input  logic [IDX_W-1:0] inj_line,
    input  logic [BIT_W-1:0] inj_bit,
    output logic [CNT_W-1:0] refetch_count
);
    localparam int TAG_W = AW - IDX_W;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [W-1:0]  wdata;
    } pend_req_t;

    pwc_state_e state_q;
    pend_req_t  pend_q;
    logic [W-1:0] rdata_q;

    // lookup
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic             rd_valid, rd_par, calc_par;
    logic [TAG_W-1:0] rd_tag;
    logic [W-1:0]     rd_data;
    logic             tag_hit, par_ok, clean_hit, req_fire, par_err;

    // array write side
    logic             fill, store_upd, wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [W-1:0]     wr_data;

    assign lk_idx = req_addr[IDX_W-1:0];
    assign lk_tag = req_addr[AW-1:IDX_W];

    pwc_array #(.W(W), .LINES(LINES), .TAG_W(TAG_W)) u_array (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_data(rd_data), .rd_par(rd_par),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .inv_en(par_err), .inv_idx(lk_idx),
        .inj_en(inj_en), .inj_idx(inj_line), .inj_bit(inj_bit)
    );

    pwc_parity #(.W(W)) u_chk (.data(rd_data), .par(calc_par));

    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_ready && req_valid;
    assign tag_hit   = rd_valid && (rd_tag == lk_tag);
    assign par_ok    = (calc_par == rd_par);
    assign clean_hit = tag_hit && par_ok;
    assign par_err   = req_fire && !req_we && tag_hit && !par_ok;

    assign fill      = (state_q == ST_MWAIT) && mem_rsp_valid;
    assign store_upd = req_fire && req_we && tag_hit;
    assign wr_en     = fill || store_upd;
    assign wr_idx    = fill ? pend_q.addr[IDX_W-1:0]  : lk_idx;
    assign wr_tag    = fill ? pend_q.addr[AW-1:IDX_W] : lk_tag;
    assign wr_data   = fill ? mem_rsp_rdata           : req_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_fire) begin
                    pend_q <= '{we: req_we, addr: req_addr, wdata: req_wdata};
                    if (!req_we && clean_hit) begin
                        rdata_q <= rd_data;
                        state_q <= ST_RESP;
                    end else begin
                        state_q <= ST_MREQ;
                    end
                end
                ST_MREQ: if (mem_req_ready)
                    state_q <= pend_q.we ? ST_RESP : ST_MWAIT;
                ST_MWAIT: if (mem_rsp_valid) begin
                    rdata_q <= mem_rsp_rdata;
                    state_q <= ST_RESP;
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_rdata     = rdata_q;
    assign mem_req_valid = (state_q == ST_MREQ);
    assign mem_req_we    = pend_q.we;
    assign mem_req_addr  = pend_q.addr;
    assign mem_req_wdata = pend_q.wdata;

    pwc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(par_err), .count(refetch_count)
    );

    p_hit_fast_r2: assert property (@(posedge clk) disable iff (rst)
        (req_fire && !req_we && clean_hit) |=> (rsp_valid && !mem_req_valid));
    p_miss_goes_down_r3: assert property (@(posedge clk) disable iff (rst)
        (req_fire && !(!req_we && clean_hit)) |=> mem_req_valid);
    p_refetch_read_r5: assert property (@(posedge clk) disable iff (rst)
        par_err |=> (mem_req_valid && !mem_req_we));
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> !req_ready);
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata)));
endmodule

// File: tb/parity_wt_cache_test.sv
`timescale 1ns/1ps
module parity_wt_cache_test;
    localparam int W = 32, AW = 12, LINES = 16, CNT_W = 8;
    localparam int IDX_W = 4, BIT_W = 6;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_we = 0, req_ready, rsp_valid;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_wdata = '0, rsp_rdata;
    logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [W-1:0]  mem_req_wdata, mem_rsp_rdata;
    logic inj_en = 0;
    logic [IDX_W-1:0] inj_line = '0;
    logic [BIT_W-1:0] inj_bit = '0;
    logic [CNT_W-1:0] refetch_count;

    parity_wt_cache #(.W(W), .AW(AW), .LINES(LINES), .CNT_W(CNT_W)) uut (.*);

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- next-level memory model ----------------
    logic [W-1:0] mem_wr [int];
    int mem_reads = 0, mem_writes = 0;
    int last_wr_addr = -1;
    logic [W-1:0] last_wr_data = '0;

    function automatic logic [W-1:0] mem_init(int a);
        return (W'(a) * 32'h9E3779B1) ^ 32'hC3A50000;
    endfunction
    function automatic logic [W-1:0] mem_val(int a);
        return mem_wr.exists(a) ? mem_wr[a] : mem_init(a);
    endfunction

    initial begin
        bit hs = 0, hs_we = 0;
        int hs_addr = 0, pend_addr = 0, rsp_cnt = 0;
        logic [W-1:0] hs_data = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_rdata = mem_val(pend_addr);
                end
            end
            if (hs) begin
                if (hs_we) begin
                    mem_wr[hs_addr] = hs_data;
                    mem_writes++;
                    last_wr_addr = hs_addr;
                    last_wr_data = hs_data;
                end else begin
                    mem_reads++;
                    pend_addr = hs_addr;
                    rsp_cnt = 1 + $urandom_range(0, 3);
                end
                hs = 0;
            end
            mem_req_ready = 1'($urandom_range(0, 1));
            if (mem_req_valid && mem_req_ready) begin
                hs = 1; hs_we = mem_req_we; hs_addr = int'(mem_req_addr); hs_data = mem_req_wdata;
            end
        end
    end

    // ---------------- bench shadow of the cache ----------------
    logic [W-1:0] exp_mem [int];
    bit              sh_valid [LINES];
    logic [AW-1:0]   sh_addr  [LINES];
    bit              sh_dmg   [LINES];
    bit              sh_pbit  [LINES];
    logic [CNT_W-1:0] exp_cnt = '0;

    function automatic logic [W-1:0] exp_val(int a);
        return exp_mem.exists(a) ? exp_mem[a] : mem_init(a);
    endfunction

    task automatic do_op(input bit we, input int addr, input logic [W-1:0] wd,
                         output int lat, output logic [W-1:0] rd);
        chk(req_ready === 1'b1, "R9 ready before request", 64'(req_ready), 1);
        req_valid = 1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            chk(req_ready === 1'b0, "R9 busy while pending", 64'(req_ready), 0);
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        chk(req_ready === 1'b0, "R9 not ready in response cycle", 64'(req_ready), 0);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 single pulse then ready",
            64'({rsp_valid, req_ready}), 64'b01);
        @(negedge clk);   // let the memory model settle
    endtask

    task automatic ld(input int addr);
        int lat, r0, idx;
        logic [W-1:0] rd;
        bit hit, perr;
        string tg;
        idx = addr % LINES;
        r0 = mem_reads;
        hit  = sh_valid[idx] && sh_addr[idx] == AW'(addr);
        perr = hit && sh_dmg[idx];
        do_op(0, addr, '0, lat, rd);
        if (perr) begin
            tg = sh_pbit[idx] ? "R6" : "R5";
            if (exp_cnt != CMAX) exp_cnt++;
            chk(rd == exp_val(addr), {tg, " refetched data"}, 64'(rd), 64'(exp_val(addr)));
            chk(mem_reads == r0 + 1, {tg, " one refetch read"}, 64'(mem_reads - r0), 1);
        end else if (hit) begin
            chk(rd == exp_val(addr), "R2 hit data", 64'(rd), 64'(exp_val(addr)));
            chk(lat == 1 && mem_reads == r0, "R2 one-cycle hit, no memory",
                64'({lat[15:0], 16'(mem_reads - r0)}), 64'({16'd1, 16'd0}));
        end else begin
            chk(rd == exp_val(addr), "R3 miss data", 64'(rd), 64'(exp_val(addr)));
            chk(mem_reads == r0 + 1, "R3 one miss read", 64'(mem_reads - r0), 1);
        end
        chk(refetch_count == exp_cnt, "R8 refetch count", 64'(refetch_count), 64'(exp_cnt));
        sh_valid[idx] = 1; sh_addr[idx] = AW'(addr); sh_dmg[idx] = 0; sh_pbit[idx] = 0;
    endtask

    task automatic st(input int addr, input logic [W-1:0] d);
        int lat, w0, idx;
        logic [W-1:0] rd;
        idx = addr % LINES;
        w0 = mem_writes;
        do_op(1, addr, d, lat, rd);
        chk(mem_writes == w0 + 1, "R7 store written through", 64'(mem_writes - w0), 1);
        chk(last_wr_addr == addr && last_wr_data == d, "R7 write address/data",
            64'(last_wr_data), 64'(d));
        exp_mem[addr] = d;
        if (sh_valid[idx] && sh_addr[idx] == AW'(addr)) begin
            sh_dmg[idx] = 0; sh_pbit[idx] = 0;
        end
    endtask

    task automatic inject(input int idx, input int b);
        inj_en = 1; inj_line = IDX_W'(idx); inj_bit = BIT_W'(b);
        @(negedge clk);
        inj_en = 0;
        sh_dmg[idx] = ~sh_dmg[idx];
        sh_pbit[idx] = (b == W);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int lat;
        logic [W-1:0] rd, base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < LINES; i++) begin
            sh_valid[i] = 0; sh_dmg[i] = 0; sh_pbit[i] = 0; sh_addr[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1 && rsp_valid === 0 && mem_req_valid === 0, "R1 reset outputs",
            64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        chk(refetch_count == 0, "R1 counter cleared", 64'(refetch_count), 0);

        ld(5);              // R1: cold miss
        ld(5);              // R2/R3: now a hit
        inject(5, 7);       // R5: data bit flip
        ld(5);
        ld(5);              // clean again after refetch
        inject(5, W);       // R6: parity bit flip
        ld(5);
        inject(5, 0); ld(5);        // R5 low edge bit
        inject(5, W - 1); ld(5);    // R5 high edge bit

        // R7 store hit updates cache; store miss does not allocate
        st(5, 32'hDEADBEEF);
        ld(5);
        st(21, 32'h12345678);       // same index, different tag
        ld(5);                      // still a one-cycle hit (R7)
        ld(21);                     // miss returns stored data

        // R10 two flips in one word pass unnoticed
        inject(5, 3); inject(5, 3);
        sh_dmg[5] = 0;
        do_op(0, 21, '0, lat, rd);
        chk(lat == 1 && rd == 32'h12345678, "R10 same bit twice restores word",
            64'(rd), 64'h12345678);
        base = exp_val(21);
        inject(5, 3); inject(5, 9);
        sh_dmg[5] = 0;
        do_op(0, 21, '0, lat, rd);
        chk(lat == 1 && rd == (base ^ 32'h0000_0208), "R10 double flip undetected",
            64'(rd), 64'(base ^ 32'h0000_0208));
        chk(refetch_count == exp_cnt, "R10 no refetch counted", 64'(refetch_count), 64'(exp_cnt));
        st(21, 32'hCAFE0021);       // overwrite the corrupted word
        ld(21);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int a, k, idx;
            a = $urandom_range(0, 63);
            k = $urandom_range(0, 99);
            idx = a % LINES;
            if (k < 45) ld(a);
            else if (k < 80) st(a, $urandom());
            else if (!sh_dmg[idx]) inject(idx, $urandom_range(0, W));
            else ld(a);
        end

        // R8 saturation
        ld(7);
        while (exp_cnt != CMAX) begin
            inject(7, $urandom_range(0, W));
            ld(7);
        end
        inject(7, 11);
        ld(7);
        chk(refetch_count == CMAX, "R8 saturates", 64'(refetch_count), 64'(CMAX));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule